// File: doc/BRIEF.md
# Three-Wire Nibble Register Master

This block is a host-side engine. It runs one register transaction at a time on a three-wire serial bus made of a clock line, a bidirectional data line and a chip-enable line. Every target register holds four bits. The block accepts a read or write request with a 4-bit register address and a 4-bit write value. It shifts out flagged command bytes and shifts in a reply byte. When the transaction ends it returns the low nibble of a read and gives a one-cycle done pulse.

The serial clock has a half period of `half_i` system clocks, where a value of 0 is treated as 1. The nominal bus half period is 700 ns, so a 100 MHz system clock uses `half_i = 70`. A separate sequencer owns the chip-enable line. This block only passes that line through from `ce_i` to `ce_o`. The data-line output enable is brought out on its own pin, so the pad can be tri-stated while the target drives a reply.

Every transaction has two bytes. A read sends one command byte, then samples one reply byte. A write sends an address byte, then a data byte.

Top module: `nibble_serial_master`

## Requirements
- R1: After reset, and whenever `busy_o` is low, `sclk_o` is 1, `sdo_oe_o` is 0 and `done_o` is 0.
- R2: Each byte takes exactly 8 serial clock low pulses. The most significant bit goes first, so bit 7 is on the line at the first falling edge and bit 0 at the last.
- R3: Each bit has a high phase and then a low phase of `sclk_o`, each H system clocks long (H = `half_i`, or 1 when `half_i` is 0). An outgoing bit is placed at the start of the high phase and held until the high phase that follows.
- R4: `sdo_oe_o` is 1 during every outgoing byte, including its first high phase. It is 0 at each falling edge of the reply byte of a read, and 0 while idle.
- R5: An incoming bit on `sdi_i` is sampled on the last system clock of a high phase, before `sclk_o` goes low.
- R6: A read sends the command byte `8'h60 | addr`: bit 6 is the read flag, bit 5 is the address flag and bits 3:0 are the address. It then receives one byte.
- R7: A write sends `8'h20 | addr` (address flag in bit 5), then `8'h10 | wdata` (data flag in bit 4, value in bits 3:0).
- R8: After a read, `rdata_o` holds bits 3:0 of the received byte, and bits 7:4 are discarded. A write leaves `rdata_o` unchanged.
- R9: Count the clock edge that samples `req_i` high in idle as the accept edge. `busy_o` is high from that edge on. `done_o` is high for exactly one cycle, after the edge 32*H+2 edges later, and `busy_o` falls on that same edge.
- R10: A request that arrives while `busy_o` is high is ignored. The bytes on the bus do not change, and no new transaction starts after done.
- R11: `ce_o` equals `ce_i` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start request, sampled only while idle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Register address |
| wdata_i | input | 4 | Write value |
| half_i | input | HALF_W | Half period of the serial clock in system clocks |
| ce_i | input | 1 | Chip enable from the sequencer |
| sdi_i | input | 1 | Serial data from the target |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| rdata_o | output | 4 | Last read nibble |
| ce_o | output | 1 | Chip enable to the bus |
| sclk_o | output | 1 | Serial clock, idles high |
| sdo_o | output | 1 | Serial data to the target |
| sdo_oe_o | output | 1 | Output enable for the data pad |

## Verification
The done pulse is due exactly 32*H+2 edges after the accept edge. The bench counts edges from the accept edge while it samples one time unit after each edge, and it compares the count with that formula for every transaction. The bit-level results are checked as they happen. A bench target model captures `sdo_o` and `sdo_oe_o` at each falling edge of `sclk_o`, times each low phase against H system clock periods, and presents reply bits on each rising edge, so that they are in place before the last high-phase clock. The byte values and the read nibble are compared only after the done pulse, and the idle state is checked on the following cycles.

// File: rtl/nsm_pkg.sv
package nsm_pkg;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] FLAG_RD = 8'h40;
  localparam logic [BYTE_W-1:0] FLAG_AD = 8'h20;
  localparam logic [BYTE_W-1:0] FLAG_DT = 8'h10;

  typedef enum logic [1:0] {ST_IDLE, ST_FIRST, ST_SECOND} nsm_state_e;

  function automatic logic [BYTE_W-1:0] first_byte(input logic wr, input logic [NIB_W-1:0] a);
    first_byte = FLAG_AD | {{(BYTE_W-NIB_W){1'b0}}, a} | (wr ? '0 : FLAG_RD);
  endfunction

  function automatic logic [BYTE_W-1:0] data_byte(input logic [NIB_W-1:0] d);
    data_byte = FLAG_DT | {{(BYTE_W-NIB_W){1'b0}}, d};
  endfunction
endpackage

// File: rtl/nsm_half_timer.sv
module nsm_half_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] half_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] lim_q, cnt_q;

  assign tick_o = run_i && (cnt_q == lim_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      lim_q <= (half_i == '0) ? '0 : half_i - CNT_W'(1);
      cnt_q <= '0;
    end else if (run_i) begin
      cnt_q <= tick_o ? '0 : cnt_q + CNT_W'(1);
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q <= lim_q); // R3
endmodule

// File: rtl/nsm_byte_shift.sv
module nsm_byte_shift
  import nsm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              tx_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [CNT_W-1:0]  half_i,
  input  logic              sdi_i,
  output logic              sclk_o,
  output logic              sdo_o,
  output logic              oe_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              done_o
);
  localparam int BIT_W = $clog2(BYTE_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  logic              active_q, low_q, tx_q, done_q, tick, load;
  logic [BIT_W-1:0]  bit_q;
  logic [BYTE_W-1:0] sh_q;

  assign load = start_i && !active_q;

  nsm_half_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .run_i  (active_q),
    .half_i (half_i),
    .tick_o (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      low_q    <= 1'b0;
      tx_q     <= 1'b0;
      done_q   <= 1'b0;
      bit_q    <= '0;
      sh_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        active_q <= 1'b1;
        low_q    <= 1'b0;
        tx_q     <= tx_i;
        bit_q    <= '0;
        sh_q     <= byte_i;
      end else if (tick) begin
        if (!low_q) begin
          low_q <= 1'b1;
          if (!tx_q) sh_q <= {sh_q[BYTE_W-2:0], sdi_i};  // sample at end of high phase
        end else begin
          low_q <= 1'b0;
          if (bit_q == LAST_BIT) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            bit_q <= bit_q + BIT_W'(1);
            if (tx_q) sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign sclk_o    = !(active_q && low_q);
  assign oe_o      = active_q && tx_q;
  assign sdo_o     = oe_o && sh_q[BYTE_W-1];
  assign rx_byte_o = sh_q;
  assign done_o    = done_q;

  AST_SDO_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o && !low_q && $past(oe_o && !low_q)) |-> $stable(sdo_o)); // R3
  AST_EIGHT_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_q) |-> $past(bit_q) == LAST_BIT); // R2
endmodule

// File: rtl/nibble_serial_master.sv
module nibble_serial_master
  import nsm_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [NIB_W-1:0]  addr_i,
  input  logic [NIB_W-1:0]  wdata_i,
  input  logic [HALF_W-1:0] half_i,
  input  logic              ce_i,
  input  logic              sdi_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [NIB_W-1:0]  rdata_o,
  output logic              ce_o,
  output logic              sclk_o,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  nsm_state_e        state_q;
  logic              wr_q, done_q, accept, sh_start, sh_tx, sh_done;
  logic [NIB_W-1:0]  addr_q, wdata_q, rdata_q;
  logic [BYTE_W-1:0] sh_byte, sh_rx;

  assign accept   = (state_q == ST_IDLE) && req_i;
  assign sh_start = accept || ((state_q == ST_FIRST) && sh_done);
  assign sh_tx    = accept ? 1'b1 : wr_q;
  assign sh_byte  = accept ? first_byte(wr_i, addr_i) : data_byte(wdata_q);

  nsm_byte_shift #(.CNT_W(HALF_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (sh_start),
    .tx_i      (sh_tx),
    .byte_i    (sh_byte),
    .half_i    (half_i),
    .sdi_i     (sdi_i),
    .sclk_o    (sclk_o),
    .sdo_o     (sdo_o),
    .oe_o      (sdo_oe_o),
    .rx_byte_o (sh_rx),
    .done_o    (sh_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          wr_q    <= wr_i;
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
          state_q <= ST_FIRST;
        end
        ST_FIRST: if (sh_done) state_q <= ST_SECOND;
        ST_SECOND: if (sh_done) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          if (!wr_q) rdata_q <= sh_rx[NIB_W-1:0];  // upper nibble dropped
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
  assign rdata_o = rdata_q;
  assign ce_o    = ce_i;

  AST_IDLE_SCLK_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (sclk_o && !sdo_oe_o)); // R1
  AST_RX_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SECOND && !wr_q) |-> !sdo_oe_o); // R4
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R9
  AST_REQ_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(addr_q) && $stable(wr_q) && $stable(wdata_q))); // R10
endmodule

// File: tb/nibble_serial_master_bench.sv
module nibble_serial_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_W     = 8;

  logic              clk_i = 1'b0, rst_ni = 1'b0;
  logic              req_i = 1'b0, wr_i = 1'b0, ce_i = 1'b0, sdi_i = 1'b0;
  logic [3:0]        addr_i = '0, wdata_i = '0;
  logic [HALF_W-1:0] half_i = 8'd1;
  logic              busy_o, done_o, ce_o, sclk_o, sdo_o, sdo_oe_o;
  logic [3:0]        rdata_o;

  int checks = 0, errors = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  nibble_serial_master #(.HALF_W(HALF_W)) u_nibble_serial_master (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .half_i(half_i), .ce_i(ce_i), .sdi_i(sdi_i), .busy_o(busy_o),
    .done_o(done_o), .rdata_o(rdata_o), .ce_o(ce_o), .sclk_o(sclk_o), .sdo_o(sdo_o),
    .sdo_oe_o(sdo_oe_o)
  );

  // target model
  logic [3:0] sl_mem [16];
  logic [3:0] exp_mem [16];
  logic [7:0] cap, resp;
  logic [7:0] got [2];
  int nbits, nbytes, rx_bits, oe_bad, width_bad, heff;
  bit rx_phase, in_txn;
  time t_fall;

  always @(negedge sclk_o) if (in_txn) begin
    t_fall = $time;
    if (rx_phase) begin
      rx_bits++;
      if (sdo_oe_o) oe_bad++;
    end else begin
      if (!sdo_oe_o) oe_bad++;
      cap = {cap[6:0], sdo_o};
      nbits++;
      if (nbits == 8) begin
        if (nbytes < 2) got[nbytes] = cap;
        nbytes++;
        nbits = 0;
        if (nbytes == 1 && cap[6]) begin
          rx_phase = 1;
          resp = {4'($urandom), sl_mem[cap[3:0]]};
        end
        if (nbytes == 2 && got[0][5] && cap[4]) sl_mem[got[0][3:0]] = cap[3:0];
      end
    end
  end

  always @(posedge sclk_o) if (in_txn) begin
    if ($time - t_fall != time'(heff * CLK_PERIOD)) width_bad++;
    if (rx_phase && rx_bits < 8) sdi_i = resp[7 - rx_bits];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_first(input logic wr, input logic [3:0] a);
    return wr ? (8'h20 | {4'h0, a}) : (8'h60 | {4'h0, a});
  endfunction

  task automatic run_txn(input logic wr, input logic [3:0] a, input logic [3:0] d,
                         input int half, input bit disturb);
    int n;
    int exp_lat;
    logic [3:0] prev_rd;
    heff = (half == 0) ? 1 : half;
    exp_lat = 32 * heff + 2;
    nbits = 0; nbytes = 0; rx_bits = 0; rx_phase = 0; oe_bad = 0; width_bad = 0;
    cap = '0; got[0] = '0; got[1] = '0;
    prev_rd = rdata_o;
    @(negedge clk_i);
    half_i = HALF_W'(half); wr_i = wr; addr_i = a; wdata_i = d; req_i = 1'b1; in_txn = 1;
    @(posedge clk_i); #1;
    req_i = 1'b0;
    n = 1;
    chk(busy_o == 1'b1, "R9 busy after accept", int'(busy_o), 1);
    while (!done_o && n < 32 * 256 + 16) begin
      if (disturb && n == 5) begin req_i = 1'b1; wr_i = ~wr; addr_i = ~a; wdata_i = ~d; end
      if (disturb && n == 6) req_i = 1'b0;
      @(posedge clk_i); #1;
      n++;
    end
    in_txn = 0;
    chk(n - 1 == exp_lat, "R9 latency", n - 1, exp_lat);
    chk(!busy_o, "R9 busy low with done", int'(busy_o), 0);
    chk(got[0] == exp_first(wr, a), wr ? "R7 addr byte" : "R6 read cmd byte",
        int'(got[0]), int'(exp_first(wr, a)));
    chk(nbytes == (wr ? 2 : 1), "R2 byte count", nbytes, wr ? 2 : 1);
    chk(oe_bad == 0, "R4 output enable", oe_bad, 0);
    chk(width_bad == 0, "R3 low phase width", width_bad, 0);
    if (wr) begin
      exp_mem[a] = d;
      chk(got[1] == (8'h10 | {4'h0, d}), "R7 data byte", int'(got[1]), int'(8'h10 | {4'h0, d}));
      chk(rdata_o == prev_rd, "R8 write keeps rdata", int'(rdata_o), int'(prev_rd));
    end else begin
      chk(rx_bits == 8, "R5 reply bits", rx_bits, 8);
      chk(rdata_o == exp_mem[a], "R8 read nibble", int'(rdata_o), int'(exp_mem[a]));
    end
    @(posedge clk_i); #1;
    chk(!done_o && sclk_o && !sdo_oe_o, "R1 idle after done", {done_o, sclk_o, sdo_oe_o}, 3'b010);
    @(posedge clk_i); #1;
    chk(!busy_o, "R10 no restart after ignored req", int'(busy_o), 0);
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog act=%0d exp=done", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 16; i++) begin sl_mem[i] = '0; exp_mem[i] = '0; end
    in_txn = 0; heff = 1; t_fall = 0;
    #(3 * CLK_PERIOD + 2);
    chk(sclk_o && !sdo_oe_o && !busy_o && !done_o, "R1 reset state",
        {sclk_o, sdo_oe_o, busy_o, done_o}, 4'b1000);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    ce_i = 1'b1; #1;
    chk(ce_o == 1'b1, "R11 ce high", int'(ce_o), 1);
    ce_i = 1'b0; #1;
    chk(ce_o == 1'b0, "R11 ce low", int'(ce_o), 0);

    // directed corners
    run_txn(1'b1, 4'hF, 4'hA, 1, 0);
    run_txn(1'b0, 4'hF, 4'h0, 0, 0);      // R3 half 0 treated as 1
    run_txn(1'b1, 4'h0, 4'h5, 3, 0);
    run_txn(1'b0, 4'h0, 4'h0, 70, 0);     // nominal 700 ns at 100 MHz
    run_txn(1'b1, 4'h7, 4'hC, 2, 1);      // R10 req while busy
    run_txn(1'b0, 4'h7, 4'h0, 2, 1);      // R10
    // random mix
    for (int k = 0; k < 40; k++) begin
      run_txn(1'($urandom), 4'($urandom), 4'($urandom), int'($urandom_range(0, 6)),
              ($urandom_range(0, 3) == 0));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule